// File: doc/BRIEF.md
# Prescaled Reloadable Interval Timer

This block is a periodic down-counter timer. A prescale stage divides a clock-enable input, which stands for whichever clock source the surrounding logic has picked. Each time the prescale stage runs out, a 32-bit main counter steps down by one. When a step is taken while the main counter already holds zero, the period has ended. The main counter then refills from a period register, a sticky overflow flag is set, and, if interrupts are enabled, a one-cycle interrupt pulse leaves the block.

Software drives the timer through a small register port: a write strobe with address and data, and a combinational read path. Through that port it programs the period and the divider, starts and halts counting, and issues a reload strobe that refills both counters at once. It can also read both live counts and clear the flag by writing a one to it.

Top module: `itv_timer_top`

## Requirements
- R1: After reset: period reads all ones, divider reads 0, control reads 0x1 (halted, interrupts off), status reads 0, the live count reads all ones, the live prescale count reads 0, and irq_pulse is low.
- R2: The main counter drops by exactly one on each prescale expiry and holds its value on every other clock, including every clock where tick_en is low.
- R3: With divider value D, the prescale count runs D, D-1 … 0 on enabled clocks, and one main-counter step happens every D+1 enabled clocks; with D = 0 a step happens on every enabled clock.
- R4: A step taken while the main counter holds 0 refills it from the period register, so with period P one interval lasts (D+1)·(P+1) enabled clocks.
- R5: irq_pulse goes high for one cycle, in the cycle after the clock edge that ends an interval, and only when the interrupt-enable bit (control bit 1) is 1.
- R6: Status bit 0 is a sticky overflow flag. It is set at every interval end whatever the interrupt enable, it is cleared by writing 1 to status bit 0, it is left alone by writing 0 there, and a set in the same cycle wins over a clear.
- R7: Writing control with bit 2 set loads the main counter from the period register and the prescale count from the divider at that edge, whether or not the timer is halted. A period end falling on the same edge is dropped. Bit 2 always reads back as 0.
- R8: While control bit 0 (halt) is 1, both counters keep their values. Clearing it resumes counting from those values on the following enabled clock.
- R9: Register addresses: 0 period (32 bits), 1 divider (16 bits), 2 control {bit2 reload, bit1 irq enable, bit0 halt}, 3 status {bit0 flag}, 4 live main count, 5 live prescale count. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Clock enable from the selected timer source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data |
| irq_pulse | output | 1 | One-cycle period-end interrupt |

## Verification
The assertions assume register writes are single-cycle strobes. They also assume that the period and the divider are not rewritten in the same cycle as a reload strobe, so each refill takes the value the register held at the previous edge. The stimulus keeps to this rule: period and divider are written only while the timer is halted, and always in a separate write before the reload. Every interval-timing check also holds tick_en high, so that enabled clocks and clock edges line up. Stalls are driven only in a stretch where no interrupt is expected.

// File: rtl/itv_pkg.sv
package itv_pkg;

  typedef enum logic [2:0] {
    RA_PERIOD = 3'd0,
    RA_DIVIDE = 3'd1,
    RA_CTRL   = 3'd2,
    RA_STATUS = 3'd3,
    RA_COUNT  = 3'd4,
    RA_PRESC  = 3'd5
  } reg_addr_e;

  localparam int ADDR_W      = 3;
  localparam int CTL_HALT    = 0;
  localparam int CTL_IRQ_EN  = 1;
  localparam int CTL_RELOAD  = 2;
  localparam int STS_FLAG    = 0;

endpackage

// File: rtl/itv_prescaler.sv
module itv_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             halt,
  input  logic             reload_req,
  input  logic [PRE_W-1:0] divider,
  output logic [PRE_W-1:0] pre_count,
  output logic             step
);

  function automatic logic [PRE_W-1:0] pre_next(input logic [PRE_W-1:0] cur,
                                                 input logic [PRE_W-1:0] div);
    return (cur == '0) ? div : cur - 1'b1;
  endfunction

  logic live_tick;
  assign live_tick = tick_en && !halt && !reload_req;
  assign step      = live_tick && (pre_count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pre_count <= '0;
    else if (reload_req) pre_count <= divider;
    else if (live_tick)  pre_count <= pre_next(pre_count, divider);
  end

  // R8: halted prescaler keeps its value unless a reload arrives
  a_r8_pre_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reload_req) |=> $stable(pre_count));

  // R3: enabled clock with a nonzero count steps the prescaler down by one
  a_r3_pre_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !halt && !reload_req && pre_count != '0) |=> pre_count == $past(pre_count) - 1'b1);

  // R7: reload takes the divider
  a_r7_pre_load: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |=> pre_count == $past(divider));

endmodule

// File: rtl/itv_counter.sv
module itv_counter #(
  parameter int          CNT_W        = 32,
  parameter logic [CNT_W-1:0] RESET_PERIOD = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             reload_req,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] cur,
                                                 input logic [CNT_W-1:0] per);
    return (cur == '0) ? per : cur - 1'b1;
  endfunction

  assign expire = step && !reload_req && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= RESET_PERIOD;
    else if (reload_req) count <= period;
    else if (step)       count <= cnt_next(count, period);
  end

  // R2: without a step or reload the count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !reload_req) |=> $stable(count));

  // R2: a step on a nonzero count is a decrement by one
  a_r2_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !reload_req && count != '0) |=> count == $past(count) - 1'b1);

  // R4: period end refills from the period register
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count == $past(period));

  // R7: reload strobe loads the period
  a_r7_cnt_load: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |=> count == $past(period));

endmodule

// File: rtl/itv_regs.sv
module itv_regs
  import itv_pkg::*;
#(
  parameter int          CNT_W        = 32,
  parameter int          PRE_W        = 16,
  parameter logic [CNT_W-1:0] RESET_PERIOD = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              expire,
  input  logic [CNT_W-1:0]  count,
  input  logic [PRE_W-1:0]  pre_count,
  output logic [CNT_W-1:0]  period,
  output logic [PRE_W-1:0]  divider,
  output logic              halt,
  output logic              irq_en,
  output logic              reload_req,
  output logic              ovf_flag,
  output logic [CNT_W-1:0]  rd_data
);

  localparam int PAD_W = CNT_W - PRE_W;

  function automatic logic [CNT_W-1:0] widen(input logic [PRE_W-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  logic wr_period, wr_divide, wr_ctrl, wr_status, flag_clear;
  assign wr_period  = wr_en && (wr_addr == RA_PERIOD);
  assign wr_divide  = wr_en && (wr_addr == RA_DIVIDE);
  assign wr_ctrl    = wr_en && (wr_addr == RA_CTRL);
  assign wr_status  = wr_en && (wr_addr == RA_STATUS);
  assign flag_clear = wr_status && wr_data[STS_FLAG];
  assign reload_req = wr_ctrl && wr_data[CTL_RELOAD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period  <= RESET_PERIOD;
      divider <= '0;
      halt    <= 1'b1;
      irq_en  <= 1'b0;
    end else begin
      if (wr_period) period  <= wr_data;
      if (wr_divide) divider <= wr_data[PRE_W-1:0];
      if (wr_ctrl) begin
        halt   <= wr_data[CTL_HALT];
        irq_en <= wr_data[CTL_IRQ_EN];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovf_flag <= 1'b0;
    else if (expire)     ovf_flag <= 1'b1;
    else if (flag_clear) ovf_flag <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_PERIOD: rd_data = period;
      RA_DIVIDE: rd_data = widen(divider);
      RA_CTRL: begin
        rd_data[CTL_HALT]   = halt;
        rd_data[CTL_IRQ_EN] = irq_en;
      end
      RA_STATUS: rd_data[STS_FLAG] = ovf_flag;
      RA_COUNT:  rd_data = count;
      RA_PRESC:  rd_data = widen(pre_count);
      default:   rd_data = '0;
    endcase
  end

  // R6: flag is set by a period end
  a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> ovf_flag);

  // R6: flag stays set until a one is written to it
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clear) |=> ovf_flag);

  // R7: the reload bit never reads back as one
  a_r7_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == RA_CTRL) |-> !rd_data[CTL_RELOAD]);

endmodule

// File: rtl/itv_timer_top.sv
module itv_timer_top
  import itv_pkg::*;
#(
  parameter int          CNT_W        = 32,
  parameter int          PRE_W        = 16,
  parameter logic [CNT_W-1:0] RESET_PERIOD = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq_pulse
);

  logic [CNT_W-1:0] period, count;
  logic [PRE_W-1:0] divider, pre_count;
  logic halt, irq_en, reload_req, ovf_flag, step, expire;

  itv_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .RESET_PERIOD(RESET_PERIOD)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .expire(expire), .count(count), .pre_count(pre_count),
    .period(period), .divider(divider), .halt(halt), .irq_en(irq_en),
    .reload_req(reload_req), .ovf_flag(ovf_flag), .rd_data(rd_data)
  );

  itv_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .halt(halt),
    .reload_req(reload_req), .divider(divider), .pre_count(pre_count), .step(step)
  );

  itv_counter #(.CNT_W(CNT_W), .RESET_PERIOD(RESET_PERIOD)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .reload_req(reload_req),
    .period(period), .count(count), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_pulse <= 1'b0;
    else        irq_pulse <= expire && irq_en;
  end

  // R5: a pulse only follows a period end
  a_r5_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(expire));

  // R5: a pulse only when interrupts were enabled
  a_r5_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(irq_en));

  // R8: halted main counter keeps its value unless reloaded
  a_r8_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reload_req) |=> $stable(count));

endmodule

// File: tb/sim_itv_timer_top.sv
module sim_itv_timer_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic irq_pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  itv_timer_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_pulse(irq_pulse)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every pulse must match the next expected edge number.
  always @(negedge clk) begin
    if (rst_n && irq_pulse) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5: actual pulse at %0d expected none", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL R4: actual pulse at %0d expected %0d", cyc, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d, output int edge_no);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    edge_no = cyc;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  // Counting model written from R2..R4: refill both counts, then n enabled clocks.
  task automatic model(input int unsigned p, input int unsigned d, input int n,
                       output int unsigned c, output int unsigned q);
    c = p; q = d;
    for (int i = 0; i < n; i++) begin
      if (q == 0) begin
        q = d;
        if (c == 0) c = p; else c = c - 1;
      end else q = q - 1;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int e, s, r;
    int unsigned mc, mq;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state, R9 map
    rd(3'd0, v); chk("R1 period", v, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R1 divider", v, 0);
    rd(3'd2, v); chk("R1 control", v, 1);
    rd(3'd3, v); chk("R1 status", v, 0);
    rd(3'd4, v); chk("R1 count", v, 32'hFFFF_FFFF);
    rd(3'd5, v); chk("R1 prescale", v, 0);
    chk("R1 irq", irq_pulse, 0);

    // R7 reload while halted; bit 2 reads as zero
    wr(3'd0, 32'd3, e);
    wr(3'd1, 32'd1, e);
    wr(3'd2, 32'h7, e);
    rd(3'd4, v); chk("R7 count load", v, 3);
    rd(3'd5, v); chk("R7 prescale load", v, 1);
    rd(3'd2, v); chk("R7 reload reads 0", v, 3);

    // R8 halted counters hold
    repeat (5) @(posedge clk);
    rd(3'd4, v); chk("R8 count frozen", v, 3);
    rd(3'd5, v); chk("R8 prescale frozen", v, 1);

    // R3/R4/R5: divider 1, period 3 -> 8 clocks per interval
    wr(3'd2, 32'h2, e);
    exp_q.push_back(e + 8);
    exp_q.push_back(e + 16);
    exp_q.push_back(e + 24);
    repeat (26) @(posedge clk);
    wr(3'd2, 32'h3, s);
    model(3, 1, s - e, mc, mq);
    rd(3'd4, v); chk("R2 count after halt", v, mc);
    rd(3'd5, v); chk("R3 prescale after halt", v, mq);
    rd(3'd3, v); chk("R6 flag set", v, 1);

    // R6 write-one-to-clear
    wr(3'd3, 32'h0, e);
    rd(3'd3, v); chk("R6 write 0 keeps flag", v, 1);
    wr(3'd3, 32'h1, e);
    rd(3'd3, v); chk("R6 write 1 clears flag", v, 0);

    // R5 interrupts disabled: flag still sets, no pulse (monitor queue empty)
    wr(3'd0, 32'd1, e);
    wr(3'd1, 32'd0, e);
    wr(3'd2, 32'h5, e);
    wr(3'd2, 32'h0, e);
    repeat (6) @(posedge clk);
    rd(3'd3, v); chk("R5 flag without irq", v, 1);

    // R2 tick_en low stalls both counters
    @(negedge clk) tick_en = 1'b0;
    rd(3'd4, v);
    repeat (5) @(posedge clk);
    rd(3'd4, v2); chk("R2 stall holds count", v2, v);
    @(negedge clk) tick_en = 1'b1;
    wr(3'd2, 32'h1, e);
    wr(3'd3, 32'h1, e);

    // R3 divider 0, period 4 -> 5 clocks; R7 reload while running
    wr(3'd0, 32'd4, e);
    wr(3'd1, 32'd0, e);
    wr(3'd2, 32'h6, e);
    exp_q.push_back(e + 5);
    repeat (6) @(posedge clk);
    wr(3'd2, 32'h6, r);
    chk("R7 reload edge", r - e, 7);
    exp_q.push_back(r + 5);
    exp_q.push_back(r + 10);
    repeat (11) @(posedge clk);
    wr(3'd2, 32'h3, s);
    model(4, 0, s - r, mc, mq);
    rd(3'd4, v); chk("R3 count after restart", v, mc);
    rd(3'd5, v); chk("R3 prescale stays 0", v, mq);
    rd(3'd6, v); chk("R9 unused address", v, 0);

    repeat (5) @(posedge clk);
    chk("R5 all pulses seen", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule